// File: doc/BRIEF.md
# Reservoir Sampling Snapshot Selector

This block picks which points of a long run are kept as replayable snapshots when the total length of the run is not known in advance. A fixed pool of `NSLOT` storage slots is maintained so that at the end of the run it holds `NSLOT` points drawn uniformly and without repetition. The target advances one cycle per accepted tick on the `tick_valid`/`tick_ready` stream. Every `PERIOD` accepted ticks, one tick is a candidate point. The selector numbers the candidates with a saturating counter `k`. The first `NSLOT` candidates are always kept. Each later candidate is kept with probability `NSLOT/k` and overwrites a randomly chosen slot. The random values come from an on-chip 32-bit LFSR.

A kept candidate appears on the record stream (`rec_valid`/`rec_ready`). The record carries the slot to overwrite, the target cycle number, the candidate index and a drain indication. The drain indication names the slot of the previous record. That record's trace window is now complete, so its I/O trace may be read out, unless the new record overwrites that slot. Back-pressure rule: a record is held unchanged while `rec_ready` is low, and `tick_ready` stays low for the whole hold. The target is therefore frozen and no tick is counted while a decision is waiting for the capture logic. A tick is counted only in a cycle where `tick_valid` and `tick_ready` are both high. A record is consumed in a cycle where `rec_valid` and `rec_ready` are both high.

Top module: `reservoir_picker`

## Requirements
- R1: After a synchronous active-low reset, `rec_valid` is 0 and `tick_ready` is 1.
- R2: Accepted ticks are numbered from 0. A tick whose number c is a multiple of `PERIOD` is a candidate. Its record appears on the record port in the cycle after the tick is accepted, with `rec_cycle` = c and `rec_k` = the 1-based candidate index.
- R3: Candidates 1 to `NSLOT` are always recorded, and candidate k goes into slot k-1.
- R4: For a candidate with k > `NSLOT`, let rnd be the current 32-bit random value and r = floor(rnd*k / 2^32). The candidate is recorded only if r < `NSLOT`, and then `rec_slot` = r.
- R5: The random source is a right-shifting Galois LFSR. When its bit 0 is 1, the shifted value is XORed with 0x80200003. Reset loads it from `seed`, and a zero seed is replaced by 1. Each candidate, including the first `NSLOT`, uses the current value and then steps the LFSR exactly once.
- R6: The candidate index saturates at 2^`KW`-1 and never wraps.
- R7: While `rec_valid` is 1 and `rec_ready` is 0, the record fields stay stable and `tick_ready` is 0. Ticks offered during this hold are not counted.
- R8: `rec_drain` is 1 when an earlier record exists and its slot differs from the current `rec_slot`, and `rec_drain_slot` then equals that earlier slot. It is 0 for the first record after reset.
- R9: A tick that is not a candidate, or a candidate that is rejected, produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed | input | 32 | LFSR seed, loaded during reset |
| tick_valid | input | 1 | Target wants to advance one cycle |
| tick_ready | output | 1 | Tick may be accepted this cycle |
| rec_valid | output | 1 | A record decision is presented |
| rec_ready | input | 1 | Capture logic takes the record |
| rec_slot | output | SW | Slot to overwrite |
| rec_cycle | output | TW | Target cycle number of the snapshot |
| rec_k | output | KW | Candidate index (saturating) |
| rec_drain | output | 1 | Previous record's trace may be read out |
| rec_drain_slot | output | SW | Slot of that previous record |

## Verification
Two of the block's functions can fall in the same cycle: holding a record under back-pressure, and accepting the next tick from the target. The bench provokes this by dropping `rec_ready` after a record and then offering ticks. It judges the result by `tick_ready` being low, the record fields staying unchanged, and the later records showing cycle numbers and candidate indices that count none of the stalled ticks. Long runs with several seeds compare every record against an independent model of the LFSR and the multiply-high acceptance test, through the saturation of the candidate index.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam logic [31:0] LFSR_MASK = 32'h8020_0003;

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    logic [31:0] t;
    t = s >> 1;
    if (s[0]) t = t ^ LFSR_MASK;
    return t;
  endfunction
endpackage

// File: rtl/rsv_lfsr.sv
module rsv_lfsr
  import rsv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] seed,
  input  logic        step,
  output logic [31:0] rnd
);
  always_ff @(posedge clk) begin
    if (!rst_n) rnd <= (seed == 32'd0) ? 32'd1 : seed;
    else if (step) rnd <= lfsr_next(rnd);
  end

  p_lfsr_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rnd != 32'd0);
  p_lfsr_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> rnd != $past(rnd));
endmodule

// File: rtl/rsv_tally.sv
module rsv_tally #(
  parameter int PERIOD = 16,
  parameter int TW     = 32,
  parameter int KW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  output logic          cand,
  output logic [TW-1:0] cyc_now,
  output logic [KW-1:0] k_next
);
  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PERIOD - 1);
  localparam logic [KW-1:0] KMAX  = {KW{1'b1}};

  logic [PW-1:0] phase;
  logic [KW-1:0] k;

  assign cand   = fire && (phase == '0);
  assign k_next = (k == KMAX) ? k : k + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      cyc_now <= '0;
      k       <= '0;
    end else if (fire) begin
      cyc_now <= cyc_now + 1'b1;
      phase   <= (phase == PLAST) ? '0 : phase + 1'b1;
      if (cand) k <= k_next;
    end
  end

  p_k_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (k == KMAX) |=> (k == KMAX));
  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PLAST);
endmodule

// File: rtl/rsv_judge.sv
module rsv_judge #(
  parameter int NSLOT = 8,
  parameter int KW    = 16
) (
  input  logic [KW-1:0] k_next,
  input  logic [31:0]   rnd,
  output logic          accept,
  output logic [((NSLOT > 1) ? $clog2(NSLOT) : 1)-1:0] slot
);
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int MW = 32 + KW;
  localparam logic [KW-1:0] NK = KW'(NSLOT);

  logic [MW-1:0] prod;
  logic [KW-1:0] r;
  logic [KW-1:0] kdec;

  always_comb begin
    prod = MW'(rnd) * MW'(k_next);
    r    = prod[MW-1:32];
    kdec = k_next - 1'b1;
    if (k_next <= NK) begin
      accept = 1'b1;
      slot   = kdec[SW-1:0];
    end else begin
      accept = (r < NK);
      slot   = r[SW-1:0];
    end
  end
endmodule

// File: rtl/reservoir_picker.sv
module reservoir_picker #(
  parameter int NSLOT  = 8,
  parameter int PERIOD = 16,
  parameter int TW     = 32,
  parameter int KW     = 16,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   seed,
  input  logic          tick_valid,
  output logic          tick_ready,
  output logic          rec_valid,
  input  logic          rec_ready,
  output logic [SW-1:0] rec_slot,
  output logic [TW-1:0] rec_cycle,
  output logic [KW-1:0] rec_k,
  output logic          rec_drain,
  output logic [SW-1:0] rec_drain_slot
);
  logic          fire, cand, accept;
  logic [TW-1:0] cyc_now;
  logic [KW-1:0] k_next;
  logic [31:0]   rnd;
  logic [SW-1:0] pick;
  logic          have_prev;
  logic [SW-1:0] prev_slot;

  assign tick_ready = !rec_valid || rec_ready;
  assign fire       = tick_valid && tick_ready;

  rsv_tally #(.PERIOD(PERIOD), .TW(TW), .KW(KW)) u_tally (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .cand(cand), .cyc_now(cyc_now), .k_next(k_next)
  );

  rsv_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .seed(seed), .step(cand), .rnd(rnd)
  );

  rsv_judge #(.NSLOT(NSLOT), .KW(KW)) u_judge (
    .k_next(k_next), .rnd(rnd), .accept(accept), .slot(pick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid      <= 1'b0;
      rec_slot       <= '0;
      rec_cycle      <= '0;
      rec_k          <= '0;
      rec_drain      <= 1'b0;
      rec_drain_slot <= '0;
      have_prev      <= 1'b0;
      prev_slot      <= '0;
    end else if (cand && accept) begin
      rec_valid      <= 1'b1;
      rec_slot       <= pick;
      rec_cycle      <= cyc_now;
      rec_k          <= k_next;
      rec_drain      <= have_prev && (prev_slot != pick);
      rec_drain_slot <= prev_slot;
      have_prev      <= 1'b1;
      prev_slot      <= pick;
    end else if (rec_ready) begin
      rec_valid <= 1'b0;
    end
  end

  p_fill_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && (rec_k <= KW'(NSLOT)) |-> rec_slot == SW'(rec_k - 1'b1));
  p_slot_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> ({1'b0, rec_slot} < (SW+1)'(NSLOT)));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_slot)
      && $stable(rec_cycle) && $stable(rec_k) && $stable(rec_drain));
  p_drain_differs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_drain |-> rec_drain_slot != rec_slot);
  p_grid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_cycle % TW'(PERIOD)) == '0);
endmodule

// File: tb/sim_reservoir_picker.sv
module sim_reservoir_picker;
  localparam int N  = 4;
  localparam int L  = 3;
  localparam int TW = 32;
  localparam int KW = 6;
  localparam int SW = 2;
  localparam int KMAX = 63;

  localparam logic [31:0] SEEDS [4] = '{32'h1234_5678, 32'h0, 32'hDEAD_BEEF, 32'h0000_0001};
  localparam int          TICKS [4] = '{60, 45, 300, 90};

  logic clk = 0, rst_n = 0;
  logic [31:0] seed = 32'h1;
  logic tick_valid = 0, rec_ready = 1;
  logic tick_ready, rec_valid, rec_drain;
  logic [SW-1:0] rec_slot, rec_drain_slot;
  logic [TW-1:0] rec_cycle;
  logic [KW-1:0] rec_k;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  reservoir_picker #(.NSLOT(N), .PERIOD(L), .TW(TW), .KW(KW)) u0 (
    .clk(clk), .rst_n(rst_n), .seed(seed), .tick_valid(tick_valid),
    .tick_ready(tick_ready), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_slot(rec_slot), .rec_cycle(rec_cycle), .rec_k(rec_k),
    .rec_drain(rec_drain), .rec_drain_slot(rec_drain_slot)
  );

  // independent model
  int m_cyc, m_phase, m_k, m_prev;
  logic m_have;
  logic [31:0] m_lfsr;
  logic e_v, e_dr;
  int e_slot, e_cyc, e_k, e_dslot;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset(input logic [31:0] s);
    m_cyc = 0; m_phase = 0; m_k = 0; m_prev = 0; m_have = 0;
    m_lfsr = (s == 0) ? 32'd1 : s;
  endtask

  task automatic model_step;
    logic [63:0] p;
    int r, k;
    bit cand;
    cand = (m_phase == 0);
    e_cyc = m_cyc;
    m_cyc++;
    m_phase = (m_phase == L-1) ? 0 : m_phase + 1;
    e_v = 0;
    if (cand) begin
      k = (m_k == KMAX) ? m_k : m_k + 1;
      m_k = k;
      p = {32'd0, m_lfsr} * 64'(k);
      r = int'(p[63:32]);
      m_lfsr = (m_lfsr[0]) ? ((m_lfsr >> 1) ^ 32'h8020_0003) : (m_lfsr >> 1);
      if (k <= N) begin e_v = 1; e_slot = k - 1; end
      else if (r < N) begin e_v = 1; e_slot = r; end
      if (e_v) begin
        e_k = k;
        e_dr = m_have && (m_prev != e_slot);
        e_dslot = m_prev;
        m_prev = e_slot; m_have = 1;
      end
    end
  endtask

  task automatic compare;
    chk(rec_valid == e_v, "R9/R4 record presence", rec_valid, e_v);
    if (e_v && rec_valid) begin
      chk(rec_slot == e_slot, (e_k <= N) ? "R3 fill slot" : "R4 victim slot", rec_slot, e_slot);
      chk(rec_cycle == e_cyc, "R2 cycle", rec_cycle, e_cyc);
      chk(rec_k == e_k, (e_k == KMAX) ? "R6 saturated k" : "R2 index k", rec_k, e_k);
      chk(rec_drain == e_dr, "R8 drain flag", rec_drain, e_dr);
      if (e_dr) chk(rec_drain_slot == e_dslot, "R8 drain slot", rec_drain_slot, e_dslot);
    end
  endtask

  task automatic do_tick;
    @(negedge clk); tick_valid = 1;
    @(negedge clk); tick_valid = 0;
    model_step();
    compare();
  endtask

  task automatic do_reset(input logic [31:0] s);
    @(negedge clk); rst_n = 0; seed = s; rec_ready = 1; tick_valid = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    model_reset(s);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(32'hACE1_0000);
    chk(rec_valid == 0, "R1 rec_valid at reset", rec_valid, 0);
    chk(tick_ready == 1, "R1 tick_ready at reset", tick_ready, 1);

    // table walk: seeds (incl. zero seed, R5) and run lengths (long one reaches R6 saturation)
    for (int t = 0; t < 4; t++) begin
      do_reset(SEEDS[t]);
      for (int i = 0; i < TICKS[t]; i++) do_tick();
    end

    // R7 back-pressure colliding with offered ticks
    do_reset(32'h0BAD_F00D);
    rec_ready = 0;
    do_tick();
    chk(rec_valid == 1, "R7 first record present", rec_valid, 1);
    @(negedge clk); tick_valid = 1;
    @(negedge clk);
    chk(tick_ready == 0, "R7 tick_ready low during hold", tick_ready, 0);
    @(negedge clk);
    chk(rec_valid == 1, "R7 record held", rec_valid, 1);
    chk(rec_slot == 0, "R7 slot stable", rec_slot, 0);
    chk(rec_cycle == 0, "R7 cycle stable", rec_cycle, 0);
    tick_valid = 0; rec_ready = 1;
    @(negedge clk);
    chk(rec_valid == 0, "R7 record consumed", rec_valid, 0);
    // stalled ticks must not have been counted
    for (int i = 0; i < 12; i++) do_tick();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule